// File: doc/BRIEF.md
# Physical Register Free List

This block keeps the pool of unused physical register numbers for a six-lane rename stage. The pool is a circular queue: a speculative head hands entries out, and a tail takes released registers back. In the same cycle as the request, each requesting rename lane is granted a register. Lanes that retire a register write its number back at the tail. A second head pointer follows instruction commit, so it always marks the point the queue held in committed state.

When a redirect arrives, the speculative head moves back to the committed head, or to a snapshot head supplied from outside. A walk then moves it forward again by the number of replayed destinations in each cycle. The queue contents are left untouched during this recovery, because every entry between the committed head and the tail is still valid data. Allocation is gated by a free count that is held in a register, so the grant path does not depend on the pointer subtraction.

Top module: `phys_free_list`

## Requirements
- R1: After reset, queue entry i holds register number ARCH_REGS+i for every i below DEPTH, the queue is full, and both heads and the tail point at entry 0 (the tail with the opposite wrap flag).
- R2: Each lane with its request bit set receives the next queue entry in lane order, counting only requesting lanes, on alloc_preg_o in the same cycle. Lanes that do not request are skipped.
- R3: The head advances by the number of requesting lanes only when alloc_en_i and can_alloc_o are both high and neither redirect_i nor walk_i is high. Otherwise no entry is consumed.
- R4: When neither redirect_i nor walk_i is high, each lane with free_en_i set writes free_preg_i at the tail in lane order, and the tail advances by that count. During redirect or walk, releases are ignored.
- R5: Each pointer is an index plus a wrap flag that inverts when the index passes the last entry. Equal index with different flags is full (DEPTH free). Equal index with equal flags is empty. The free count never exceeds DEPTH.
- R6: can_alloc_o is high exactly when the free count, registered one cycle after the pointer update, is greater than LANES.
- R7: While commit_i is high, the committed head advances by the number of lanes that are valid and write this register file. With IS_INT set, a lane also needs a nonzero logical destination and must not be an eliminated move. The committed head holds when commit_i is low.
- R8: redirect_i with use_snap_i low loads the speculative head with the committed head.
- R9: redirect_i with use_snap_i high loads the speculative head with snap_head_i, given as {wrap flag, index}.
- R10: While walk_i is high, the speculative head advances each cycle by the population count of walk_req_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_en_i | input | 1 | Rename stage accepts this cycle's allocation |
| alloc_req_i | input | LANES | Per-lane request for a destination register |
| alloc_preg_o | output | LANES x PREG_W | Register granted to each lane |
| can_alloc_o | output | 1 | Enough free registers for a full rename group |
| free_en_i | input | LANES | Per-lane release valid |
| free_preg_i | input | LANES x PREG_W | Register number released on each lane |
| commit_i | input | 1 | Commit cycle marker |
| commit_valid_i | input | LANES | Per-lane commit valid |
| commit_wen_i | input | LANES | Lane writes a register of this file |
| commit_ldest_i | input | LANES x LDEST_W | Logical destination of each committing lane |
| commit_move_i | input | LANES | Lane is an eliminated move |
| redirect_i | input | 1 | Pipeline redirect, restores the head |
| use_snap_i | input | 1 | Restore from snap_head_i instead of the committed head |
| snap_head_i | input | IDX_W+1 | Snapshot head pointer {flag, index} |
| walk_i | input | 1 | Walk replay active |
| walk_req_i | input | LANES | Per-lane replayed destination |

## Verification
The bench builds the block with DEPTH 16, ARCH_REGS 8, LANES 6 and the integer commit filter enabled. A queue that small lets a few dozen release and allocate cycles wrap both pointers several times. It also brings the free count down to the gate threshold of six, and back up to exactly full, where the wrap flags alone separate full from empty. The reduced depth keeps redirect distances short enough that the committed head, a snapshot head and a three-cycle walk can each be read back through the next lane-0 grant.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam int unsigned MAX_LANES = 16;
  localparam int unsigned CNT_W     = 5;

  typedef enum logic [1:0] {
    HEAD_HOLD,
    HEAD_ALLOC,
    HEAD_RESTORE,
    HEAD_WALK
  } head_sel_e;

  function automatic logic [CNT_W-1:0] count_ones(input logic [MAX_LANES-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < MAX_LANES; i++) c = c + {{(CNT_W-1){1'b0}}, v[i]};
    return c;
  endfunction
endpackage

// File: rtl/fl_ptr_adv.sv
module fl_ptr_adv
  import fl_pkg::*;
#(
  parameter  int unsigned DEPTH = 224,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W:0]   ptr_i,
  input  logic [CNT_W-1:0] inc_i,
  output logic [IDX_W:0]   ptr_o
);
  int unsigned sum;

  always_comb begin
    sum = int'(ptr_i[IDX_W-1:0]) + int'(inc_i);
    if (sum >= DEPTH) ptr_o = {~ptr_i[IDX_W], IDX_W'(sum - DEPTH)};
    else              ptr_o = {ptr_i[IDX_W], IDX_W'(sum)};
  end
endmodule

// File: rtl/fl_lane_pos.sv
module fl_lane_pos
  import fl_pkg::*;
#(
  parameter  int unsigned DEPTH = 224,
  parameter  int unsigned LANES = 6,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W:0]                  base_i,
  input  logic [LANES-1:0]                mask_i,
  output logic [LANES-1:0][IDX_W-1:0]     idx_o,
  output logic [CNT_W-1:0]                total_o
);
  function automatic logic [IDX_W-1:0] wrap_idx(input logic [IDX_W-1:0] b,
                                                input logic [CNT_W-1:0] n);
    int unsigned s;
    s = int'(b) + int'(n);
    if (s >= DEPTH) s = s - DEPTH;
    return IDX_W'(s);
  endfunction

  assign total_o = count_ones(MAX_LANES'(mask_i));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CNT_W-1:0] below;
    if (l == 0) begin : g_first
      assign below = '0;
    end else begin : g_rest
      assign below = count_ones(MAX_LANES'(mask_i[l-1:0]));
    end
    assign idx_o[l] = wrap_idx(base_i[IDX_W-1:0], below);
  end
endmodule

// File: rtl/fl_storage.sv
module fl_storage #(
  parameter  int unsigned DEPTH     = 224,
  parameter  int unsigned LANES     = 6,
  parameter  int unsigned PREG_W    = 8,
  parameter  int unsigned BASE      = 32,
  localparam int unsigned IDX_W     = $clog2(DEPTH)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [LANES-1:0]                 wr_en_i,
  input  logic [LANES-1:0][IDX_W-1:0]      wr_idx_i,
  input  logic [LANES-1:0][PREG_W-1:0]     wr_data_i,
  input  logic [LANES-1:0][IDX_W-1:0]      rd_idx_i,
  output logic [LANES-1:0][PREG_W-1:0]     rd_data_o
);
  logic [PREG_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= PREG_W'(BASE + e);
    end else begin
      for (int l = 0; l < LANES; l++)
        if (wr_en_i[l]) mem_q[wr_idx_i[l]] <= wr_data_i[l];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign rd_data_o[l] = mem_q[rd_idx_i[l]];
  end
endmodule

// File: rtl/fl_head_ctrl.sv
module fl_head_ctrl
  import fl_pkg::*;
#(
  parameter  int unsigned DEPTH = 224,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_fire_i,
  input  logic [CNT_W-1:0] alloc_cnt_i,
  input  logic             commit_i,
  input  logic [CNT_W-1:0] commit_cnt_i,
  input  logic             redirect_i,
  input  logic             use_snap_i,
  input  logic [IDX_W:0]   snap_head_i,
  input  logic             walk_i,
  input  logic [CNT_W-1:0] walk_cnt_i,
  output logic [IDX_W:0]   head_q_o,
  output logic [IDX_W:0]   head_d_o,
  output logic [IDX_W:0]   arch_q_o
);
  head_sel_e        sel;
  logic [CNT_W-1:0] step_cnt;
  logic [IDX_W:0]   head_step, arch_step;

  // redirect wins over walk, walk over allocation
  always_comb begin
    if (redirect_i)        sel = HEAD_RESTORE;
    else if (walk_i)       sel = HEAD_WALK;
    else if (alloc_fire_i) sel = HEAD_ALLOC;
    else                   sel = HEAD_HOLD;
  end

  assign step_cnt = (sel == HEAD_WALK) ? walk_cnt_i : alloc_cnt_i;

  fl_ptr_adv #(.DEPTH(DEPTH)) i_head_adv (
    .ptr_i (head_q_o),
    .inc_i (step_cnt),
    .ptr_o (head_step)
  );

  fl_ptr_adv #(.DEPTH(DEPTH)) i_arch_adv (
    .ptr_i (arch_q_o),
    .inc_i (commit_cnt_i),
    .ptr_o (arch_step)
  );

  always_comb begin
    unique case (sel)
      HEAD_ALLOC, HEAD_WALK: head_d_o = head_step;
      HEAD_RESTORE:          head_d_o = use_snap_i ? snap_head_i : arch_q_o;
      default:               head_d_o = head_q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q_o <= '0;
      arch_q_o <= '0;
    end else begin
      head_q_o <= head_d_o;
      if (commit_i) arch_q_o <= arch_step;
    end
  end
endmodule

// File: rtl/phys_free_list.sv
module phys_free_list
  import fl_pkg::*;
#(
  parameter  int unsigned DEPTH     = 224,
  parameter  int unsigned ARCH_REGS = 32,
  parameter  int unsigned LANES     = 6,
  parameter  int unsigned LDEST_W   = 5,
  parameter  bit          IS_INT    = 1'b1,
  localparam int unsigned PREG_W    = $clog2(ARCH_REGS + DEPTH),
  localparam int unsigned IDX_W     = $clog2(DEPTH)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              alloc_en_i,
  input  logic [LANES-1:0]                  alloc_req_i,
  output logic [LANES-1:0][PREG_W-1:0]      alloc_preg_o,
  output logic                              can_alloc_o,
  input  logic [LANES-1:0]                  free_en_i,
  input  logic [LANES-1:0][PREG_W-1:0]      free_preg_i,
  input  logic                              commit_i,
  input  logic [LANES-1:0]                  commit_valid_i,
  input  logic [LANES-1:0]                  commit_wen_i,
  input  logic [LANES-1:0][LDEST_W-1:0]     commit_ldest_i,
  input  logic [LANES-1:0]                  commit_move_i,
  input  logic                              redirect_i,
  input  logic                              use_snap_i,
  input  logic [IDX_W:0]                    snap_head_i,
  input  logic                              walk_i,
  input  logic [LANES-1:0]                  walk_req_i
);
  localparam int unsigned CNT_Q_W = $clog2(DEPTH + 1);

  logic [IDX_W:0]                 head_q, head_d, arch_q, tail_q, tail_d;
  logic [LANES-1:0][IDX_W-1:0]    rd_idx, wr_idx;
  logic [LANES-1:0]               free_mask, commit_ok;
  logic [CNT_W-1:0]               alloc_cnt, free_cnt, commit_cnt, walk_cnt;
  logic                           alloc_fire, recovering;
  logic [CNT_Q_W-1:0]             free_cnt_q;

  function automatic logic [CNT_Q_W-1:0] ptr_dist(input logic [IDX_W:0] t,
                                                  input logic [IDX_W:0] h);
    int unsigned ti, hi;
    ti = int'(t[IDX_W-1:0]);
    hi = int'(h[IDX_W-1:0]);
    if (t[IDX_W] == h[IDX_W]) return CNT_Q_W'(ti - hi);
    else                      return CNT_Q_W'(DEPTH + ti - hi);
  endfunction

  assign recovering = redirect_i | walk_i;
  assign alloc_fire = alloc_en_i & can_alloc_o & ~recovering;
  assign free_mask  = recovering ? '0 : free_en_i;
  assign walk_cnt   = count_ones(MAX_LANES'(walk_req_i));

  for (genvar l = 0; l < LANES; l++) begin : g_commit
    if (IS_INT) begin : g_int
      assign commit_ok[l] = commit_valid_i[l] & commit_wen_i[l]
                          & (|commit_ldest_i[l]) & ~commit_move_i[l];
    end else begin : g_std
      assign commit_ok[l] = commit_valid_i[l] & commit_wen_i[l];
    end
  end
  assign commit_cnt = count_ones(MAX_LANES'(commit_ok));

  fl_lane_pos #(.DEPTH(DEPTH), .LANES(LANES)) i_alloc_pos (
    .base_i  (head_q),
    .mask_i  (alloc_req_i),
    .idx_o   (rd_idx),
    .total_o (alloc_cnt)
  );

  fl_lane_pos #(.DEPTH(DEPTH), .LANES(LANES)) i_free_pos (
    .base_i  (tail_q),
    .mask_i  (free_mask),
    .idx_o   (wr_idx),
    .total_o (free_cnt)
  );

  fl_storage #(
    .DEPTH  (DEPTH),
    .LANES  (LANES),
    .PREG_W (PREG_W),
    .BASE   (ARCH_REGS)
  ) i_storage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (free_mask),
    .wr_idx_i  (wr_idx),
    .wr_data_i (free_preg_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (alloc_preg_o)
  );

  fl_head_ctrl #(.DEPTH(DEPTH)) i_head_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_fire_i (alloc_fire),
    .alloc_cnt_i  (alloc_cnt),
    .commit_i     (commit_i),
    .commit_cnt_i (commit_cnt),
    .redirect_i   (redirect_i),
    .use_snap_i   (use_snap_i),
    .snap_head_i  (snap_head_i),
    .walk_i       (walk_i),
    .walk_cnt_i   (walk_cnt),
    .head_q_o     (head_q),
    .head_d_o     (head_d),
    .arch_q_o     (arch_q)
  );

  fl_ptr_adv #(.DEPTH(DEPTH)) i_tail_adv (
    .ptr_i (tail_q),
    .inc_i (free_cnt),
    .ptr_o (tail_d)
  );

  // queue starts full: tail index 0 with inverted flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_q     <= {1'b1, {IDX_W{1'b0}}};
      free_cnt_q <= CNT_Q_W'(DEPTH);
    end else begin
      tail_q     <= tail_d;
      free_cnt_q <= ptr_dist(tail_d, head_d);
    end
  end

  assign can_alloc_o = free_cnt_q > CNT_Q_W'(LANES);
endmodule

// File: rtl/fl_checker.sv
module fl_checker #(
  parameter  int unsigned DEPTH = 224,
  parameter  int unsigned LANES = 6,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_Q_W = $clog2(DEPTH + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               alloc_en_i,
  input logic               can_alloc_o,
  input logic               redirect_i,
  input logic               use_snap_i,
  input logic [IDX_W:0]     snap_head_i,
  input logic               walk_i,
  input logic               commit_i,
  input logic [IDX_W:0]     head_q,
  input logic [IDX_W:0]     tail_q,
  input logic [IDX_W:0]     arch_q,
  input logic [CNT_Q_W-1:0] free_cnt_q
);
  AST_HEAD_HOLD_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!redirect_i && !walk_i && !(alloc_en_i && can_alloc_o)) |=> head_q == $past(head_q)); // R3

  AST_TAIL_HOLD_RECOVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_i || walk_i) |=> tail_q == $past(tail_q)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_cnt_q <= CNT_Q_W'(DEPTH)); // R5

  AST_ARCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> arch_q == $past(arch_q)); // R7

  AST_RESTORE_ARCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_i && !use_snap_i) |=> head_q == $past(arch_q)); // R8

  AST_RESTORE_SNAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_i && use_snap_i) |=> head_q == $past(snap_head_i)); // R9
endmodule

bind phys_free_list fl_checker #(.DEPTH(DEPTH), .LANES(LANES)) i_fl_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .alloc_en_i  (alloc_en_i),
  .can_alloc_o (can_alloc_o),
  .redirect_i  (redirect_i),
  .use_snap_i  (use_snap_i),
  .snap_head_i (snap_head_i),
  .walk_i      (walk_i),
  .commit_i    (commit_i),
  .head_q      (head_q),
  .tail_q      (tail_q),
  .arch_q      (arch_q),
  .free_cnt_q  (free_cnt_q)
);

// File: tb/test_phys_free_list.sv
module test_phys_free_list;
  localparam int unsigned D  = 16;
  localparam int unsigned AR = 8;
  localparam int unsigned L  = 6;
  localparam int unsigned LW = 5;
  localparam int unsigned PW = $clog2(AR + D);
  localparam int unsigned IW = $clog2(D);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic                    alloc_en;
  logic [L-1:0]            alloc_req;
  logic [L-1:0][PW-1:0]    alloc_preg;
  logic                    can_alloc;
  logic [L-1:0]            free_en;
  logic [L-1:0][PW-1:0]    free_preg;
  logic                    commit;
  logic [L-1:0]            c_valid, c_wen, c_move;
  logic [L-1:0][LW-1:0]    c_ldest;
  logic                    redirect, use_snap;
  logic [IW:0]             snap_head;
  logic                    walk;
  logic [L-1:0]            walk_req;

  always #10 clk_i = ~clk_i;

  phys_free_list #(
    .DEPTH(D), .ARCH_REGS(AR), .LANES(L), .LDEST_W(LW), .IS_INT(1'b1)
  ) i_phys_free_list (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .alloc_en_i(alloc_en), .alloc_req_i(alloc_req), .alloc_preg_o(alloc_preg),
    .can_alloc_o(can_alloc),
    .free_en_i(free_en), .free_preg_i(free_preg),
    .commit_i(commit), .commit_valid_i(c_valid), .commit_wen_i(c_wen),
    .commit_ldest_i(c_ldest), .commit_move_i(c_move),
    .redirect_i(redirect), .use_snap_i(use_snap), .snap_head_i(snap_head),
    .walk_i(walk), .walk_req_i(walk_req)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int mq [D];
  int mh, mt, ma;
  int pool [512];
  int p_wr = 0;
  int p_rd = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    alloc_en = 1'b0; alloc_req = '0; free_en = '0; free_preg = '0;
    commit = 1'b0; c_valid = '0; c_wen = '0; c_ldest = '0; c_move = '0;
    redirect = 1'b0; use_snap = 1'b0; snap_head = '0; walk = 1'b0; walk_req = '0;
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic check_can(input string req);
    check({req, " can_alloc"}, int'(can_alloc), (mt - mh > int'(L)) ? 1 : 0);
  endtask

  task automatic alloc_step(input string req, input logic en, input logic [L-1:0] mask);
    int k;
    logic fire;
    alloc_en = en; alloc_req = mask;
    #1;
    k = 0;
    for (int l = 0; l < L; l++)
      if (mask[l]) begin
        check({req, " grant"}, int'(alloc_preg[l]), mq[(mh + k) % D]);
        k++;
      end
    fire = en && (mt - mh > int'(L));
    if (fire) begin
      for (int l = 0; l < L; l++)
        if (mask[l]) begin
          pool[p_wr % 512] = int'(alloc_preg[l]);
          p_wr++;
        end
      mh += k;
    end
    tick();
    idle();
    check_can(req);
  endtask

  task automatic commit_free_step(input string req, input int ncommit, input int nfree);
    commit = (ncommit > 0);
    for (int l = 0; l < ncommit; l++) begin
      c_valid[l] = 1'b1; c_wen[l] = 1'b1; c_ldest[l] = LW'(l + 1);
    end
    for (int j = 0; j < nfree; j++) begin
      free_en[j] = 1'b1;
      free_preg[j] = PW'(pool[p_rd % 512]);
      mq[(mt + j) % D] = pool[p_rd % 512];
      p_rd++;
    end
    tick();
    mt += nfree;
    ma += ncommit;
    idle();
    check_can(req);
  endtask

  // junk releases and allocation requests ride along and must be ignored
  task automatic redirect_step(input string req, input logic snap_sel, input int snap);
    redirect = 1'b1; use_snap = snap_sel; snap_head = (IW+1)'(snap % (2 * D));
    free_en = '1; free_preg = '1; alloc_en = 1'b1; alloc_req = '1;
    tick();
    mh = snap_sel ? snap : ma;
    idle();
    check_can(req);
  endtask

  task automatic walk_step(input string req, input logic [L-1:0] mask);
    walk = 1'b1; walk_req = mask;
    free_en = '1; free_preg = '1; alloc_en = 1'b1; alloc_req = '1;
    tick();
    mh += $countones(mask);
    idle();
    check_can(req);
  endtask

  task automatic t_reset();
    check("R1 reset can_alloc", int'(can_alloc), 1);
    alloc_step("R1 R2 reset contents", 1'b1, 6'b111111);
  endtask

  task automatic t_sparse_lanes();
    alloc_step("R2 sparse lanes", 1'b1, 6'b101010);
  endtask

  task automatic t_gate();
    alloc_step("R3 disabled", 1'b0, 6'b111111);
    alloc_step("R6 threshold", 1'b1, 6'b000001);
    check("R6 low at six free", int'(can_alloc), 0);
    alloc_step("R3 gated", 1'b1, 6'b000001);
  endtask

  task automatic t_commit();
    commit = 1'b1; c_valid = '1; c_wen = '1;
    c_ldest = {5'd5, 5'd4, 5'd3, 5'd0, 5'd2, 5'd1};
    c_move[4] = 1'b1;
    tick(); ma += 4; idle();
    c_valid = '1; c_wen = '1; c_ldest = '1;
    tick(); idle();
    commit = 1'b1; c_valid = 6'b000111; c_wen = 6'b000101; c_ldest = '1;
    tick(); ma += 2; idle();
    commit_free_step("R4 release", 0, 6);
    alloc_step("R3 head kept while gated", 1'b1, 6'b000001);
  endtask

  task automatic t_redirect_arch();
    redirect_step("R8 restore", 1'b0, 0);
    alloc_step("R7 R8 committed head", 1'b1, 6'b000001);
  endtask

  task automatic t_walk();
    redirect_step("R10 pre-walk", 1'b0, 0);
    walk_step("R10 walk a", 6'b000011);
    walk_step("R10 walk b", 6'b101000);
    walk_step("R10 walk c", 6'b000001);
    alloc_step("R10 R4 after walk", 1'b1, 6'b000001);
  endtask

  task automatic t_snapshot();
    int snap;
    snap = mh;
    alloc_step("R9 pre-snapshot", 1'b1, 6'b000111);
    redirect_step("R9 restore", 1'b1, snap);
    alloc_step("R9 snapshot head", 1'b1, 6'b000001);
  endtask

  task automatic t_wrap();
    for (int it = 0; it < 8; it++) begin
      commit_free_step("R4 wrap release", 6, 6);
      alloc_step("R5 wrap grant", 1'b1, 6'b111111);
    end
    commit_free_step("R5 fill", 6, 6);
    commit_free_step("R5 fill last", 1, 1);
    check("R5 full count", mt - mh, int'(D));
    check("R5 full seen as full", int'(can_alloc), 1);
    alloc_step("R5 grant from full", 1'b1, 6'b111111);
  endtask

  initial begin
    idle();
    mh = 0; mt = int'(D); ma = 0;
    for (int e = 0; e < int'(D); e++) mq[e] = int'(AR) + e;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
    t_reset();
    t_sparse_lanes();
    t_gate();
    t_commit();
    t_redirect_arch();
    t_walk();
    t_snapshot();
    t_wrap();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule